// File: doc/BRIEF.md
# Two-Bit Function-Select ALU with Carry Flag

This block is the compute path of a very small 2-bit machine. It keeps no function register of its own. A write to a reserved destination address shows up as a one-cycle strobe with a value, and the low three bits of that value pick one of eight operations. The operation is applied to two 2-bit operands. The block then stores the 2-bit answer in a result register and the carry in a flag register. The flag is held as a true/complement pair, and both halves go to the ports.

A load takes two clock edges. At the strobe edge the block latches the selection and the current flag into a carry-in temporary, and it clears the result register. The flag itself is left alone. At the next edge the answer and the new flag are loaded. The operands are sampled at that second edge. The flag is set or reset directly from the combinational carry and not-carry of the top bit, with no pre-clear. The old flag can feed the add-with-carry because it was already captured in the temporary.

Top module: `tiny_alu_unit`

## Requirements
- R1: After synchronous reset, `res_o` is 0, `cy_o` is 0 and `cy_n_o` is 1.
- R2: On the edge that samples `fn_we` high, `res_o` becomes 0 and `cy_o` keeps its value.
- R3: On the edge after a strobe, the block loads the result and the flag. It uses `fn_val[2:0]` captured at the strobe and `opa`/`opb` present at this second edge. Bits of `fn_val` above bit 2 have no effect.
- R4: Code 000 (add) loads (opa+opb) mod 4. The flag is set when opa+opb is 4 or more.
- R5: Code 001 (add with carry) loads (opa+opb+F) mod 4, where F is the flag value at the strobe edge. The flag is set when that sum is 4 or more.
- R6: The logic codes clear the flag and load the following values: 010 loads opa AND opb, 011 loads OR, 100 loads XOR, 101 loads NOT opa, and 110 loads opa unchanged.
- R7: Code 111 loads (opa+1) mod 4. The flag is set only when opa is 3.
- R8: `cy_n_o` is always the complement of `cy_o` once out of reset.
- R9: With no strobe and no pending load, `res_o` and `cy_o` hold while the operands change.
- R10: A strobe that arrives on the load edge of an earlier strobe abandons that load. The result stays 0, the flag is unchanged, and the new selection is loaded one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opa | input | W | Operand A |
| opb | input | W | Operand B |
| fn_we | input | 1 | Strobe for a write to the function address |
| fn_val | input | FNV_W | Written value; low three bits select the operation |
| res_o | output | W | Result register |
| cy_o | output | 1 | Carry flag |
| cy_n_o | output | 1 | Complement of the carry flag |

## Verification
A wrong latched selection or carry-in temporary appears only at the load edge, as a wrong `res_o` or `cy_o` two cycles after the strobe. For this reason every operation is checked there, against every operand pair and both incoming flag values. A missed pre-clear or a flag that is disturbed early shows one cycle after the strobe, so that cycle is checked on every operation. A flag pair that drifts apart shows on `cy_n_o` at once. The cases of a strobe arriving on a pending load, and of operands changing while the block is idle, are each exercised directly.

// File: rtl/tiny_alu_pkg.sv
package tiny_alu_pkg;
  localparam int FN_W = 3;
  localparam int FN_N = 1 << FN_W;

  typedef enum logic [FN_W-1:0] {
    FN_ADD   = 3'd0,
    FN_ADC   = 3'd1,
    FN_AND   = 3'd2,
    FN_OR    = 3'd3,
    FN_XOR   = 3'd4,
    FN_NOTA  = 3'd5,
    FN_PASSA = 3'd6,
    FN_INCA  = 3'd7
  } fn_e;
endpackage

// File: rtl/tiny_alu_bitcell.sv
// One adder bit that forwards carry and not-carry side by side,
// so no stage waits on an inverted copy of the previous carry.
module tiny_alu_bitcell (
  input  logic a,
  input  logic b,
  input  logic ci,
  input  logic nci,
  output logic s,
  output logic co,
  output logic nco
);
  logic diff;
  assign diff = a ^ b;
  assign s    = diff ^ ci;
  assign co   = (a & b) | (diff & ci);
  assign nco  = (~a & ~b) | (diff & nci);
endmodule

// File: rtl/tiny_alu_func.sv
module tiny_alu_func
  import tiny_alu_pkg::*;
#(
  parameter int W = 2
) (
  input  fn_e          fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         co,
  output logic         nco
);
  logic [FN_N-1:0] sel;
  logic [W-1:0]    add_b;
  logic [W-1:0]    sum;
  logic [W:0]      c;
  logic [W:0]      nc;
  logic            arith;

  assign sel   = {{(FN_N-1){1'b0}}, 1'b1} << fn;
  assign arith = sel[FN_ADD] | sel[FN_ADC] | sel[FN_INCA];
  assign add_b = sel[FN_INCA] ? '0 : b;
  assign c[0]  = sel[FN_INCA] | (sel[FN_ADC] & cin);
  assign nc[0] = ~c[0];

  for (genvar i = 0; i < W; i++) begin : g_bit
    tiny_alu_bitcell u_cell (
      .a  (a[i]),
      .b  (add_b[i]),
      .ci (c[i]),
      .nci(nc[i]),
      .s  (sum[i]),
      .co (c[i+1]),
      .nco(nc[i+1])
    );
  end

  assign res = ({W{arith}}          & sum)
             | ({W{sel[FN_AND]}}   & (a & b))
             | ({W{sel[FN_OR]}}    & (a | b))
             | ({W{sel[FN_XOR]}}   & (a ^ b))
             | ({W{sel[FN_NOTA]}}  & ~a)
             | ({W{sel[FN_PASSA]}} & a);

  assign co  = arith & c[W];
  assign nco = ~arith | nc[W];
endmodule

// File: rtl/tiny_alu_flag.sv
// Carry flag kept as a set/reset pair; written directly, never pre-cleared.
module tiny_alu_flag (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic set_v,
  input  logic clr_v,
  output logic cy_q,
  output logic cyn_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cy_q  <= 1'b0;
      cyn_q <= 1'b1;
    end else if (load) begin
      if (set_v) cy_q <= 1'b1;
      else if (clr_v) cy_q <= 1'b0;
      if (clr_v) cyn_q <= 1'b1;
      else if (set_v) cyn_q <= 1'b0;
    end
  end

  p_pair_r8: assert property (@(posedge clk) disable iff (rst)
    cy_q != cyn_q) else $error("flag pair disagrees");

  p_drive_r8: assert property (@(posedge clk) disable iff (rst)
    load |-> (set_v != clr_v)) else $error("carry and not-carry collide");
endmodule

// File: rtl/tiny_alu_unit.sv
module tiny_alu_unit
  import tiny_alu_pkg::*;
#(
  parameter int W     = 2,
  parameter int FNV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     opa,
  input  logic [W-1:0]     opb,
  input  logic             fn_we,
  input  logic [FNV_W-1:0] fn_val,
  output logic [W-1:0]     res_o,
  output logic             cy_o,
  output logic             cy_n_o
);
  fn_e          fn_q;
  logic         cin_q;
  logic         pend_q;
  logic [W-1:0] res_q;
  logic [W-1:0] f_res;
  logic         f_co;
  logic         f_nco;
  logic         load;

  assign load = pend_q & ~fn_we;

  tiny_alu_func #(.W(W)) u_func (
    .fn (fn_q),
    .a  (opa),
    .b  (opb),
    .cin(cin_q),
    .res(f_res),
    .co (f_co),
    .nco(f_nco)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      pend_q <= 1'b0;
      fn_q   <= FN_ADD;
      cin_q  <= 1'b0;
    end else if (fn_we) begin
      res_q  <= '0;
      pend_q <= 1'b1;
      fn_q   <= fn_e'(fn_val[FN_W-1:0]);
      cin_q  <= cy_o;
    end else if (pend_q) begin
      res_q  <= f_res;
      pend_q <= 1'b0;
    end
  end

  tiny_alu_flag u_flag (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .set_v(f_co),
    .clr_v(f_nco),
    .cy_q (cy_o),
    .cyn_q(cy_n_o)
  );

  assign res_o = res_q;

  p_preclear_r2: assert property (@(posedge clk) disable iff (rst)
    fn_we |=> (res_q == '0 && $stable(cy_o))) else $error("strobe edge disturbed state");

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!fn_we && !pend_q) |=> ($stable(res_q) && $stable(cy_o))) else $error("idle state moved");

  p_logic_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (load && fn_q inside {FN_AND, FN_OR, FN_XOR, FN_NOTA, FN_PASSA}) |=> !cy_o)
    else $error("logic op left carry set");

  p_inc_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (load && fn_q == FN_INCA && opa == '1) |=> (cy_o && res_q == '0))
    else $error("increment wrap wrong");

  p_refire_r10: assert property (@(posedge clk) disable iff (rst)
    (pend_q && fn_we) |=> (pend_q && res_q == '0)) else $error("restrike not handled");
endmodule

// File: tb/tiny_alu_unit_tb.sv
`timescale 1ns/1ps
module tiny_alu_unit_tb_top;
  localparam int W     = 2;
  localparam int FNV_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [W-1:0]     opa = '0;
  logic [W-1:0]     opb = '0;
  logic             fn_we = 1'b0;
  logic [FNV_W-1:0] fn_val = '0;
  logic [W-1:0]     res_o;
  logic             cy_o;
  logic             cy_n_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tiny_alu_unit #(.W(W), .FNV_W(FNV_W)) dut_i (
    .clk(clk), .rst(rst), .opa(opa), .opb(opb),
    .fn_we(fn_we), .fn_val(fn_val),
    .res_o(res_o), .cy_o(cy_o), .cy_n_o(cy_n_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input int f);
    case (f)
      0: return "R4";
      1: return "R5";
      7: return "R7";
      default: return "R6";
    endcase
  endfunction

  // reference: returns {carry, result}
  function automatic int ref_op(input int f, input int a, input int b, input int ci);
    int s;
    case (f)
      0: s = a + b;
      1: s = a + b + ci;
      2: s = a & b;
      3: s = a | b;
      4: s = a ^ b;
      5: s = (~a) & 3;
      6: s = a;
      default: s = a + 1;
    endcase
    return s;
  endfunction

  task automatic do_op(input int f, input int a, input int b, input int hi);
    int expv, prev_cy;
    prev_cy = cy_o;
    expv = ref_op(f, a, b, prev_cy);
    @(negedge clk);
    fn_we  = 1'b1;
    fn_val = FNV_W'((hi << 3) | f);
    opa    = W'(~a);
    opb    = W'(b + 1);
    @(negedge clk);
    fn_we = 1'b0;
    opa   = W'(a);
    opb   = W'(b);
    chk(res_o == 0, "R2 preclear", res_o, 0);
    chk(cy_o == prev_cy, "R2 flag kept", cy_o, prev_cy);
    @(negedge clk);
    chk(res_o == (expv & 3), {tag_of(f), " result R3"}, res_o, expv & 3);
    chk(cy_o == (expv >= 4), {tag_of(f), " carry"}, cy_o, expv >= 4);
    chk(cy_n_o == !cy_o, "R8 complement", cy_n_o, !cy_o);
  endtask

  initial begin
    #(2.5 * 2 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(res_o == 0, "R1 result", res_o, 0);
    chk(cy_o == 0, "R1 flag", cy_o, 0);
    chk(cy_n_o == 1, "R1 flag complement", cy_n_o, 1);

    // exhaustive sweep: every code, operand pair and incoming flag
    for (int f = 0; f < 8; f++)
      for (int ci = 0; ci < 2; ci++)
        for (int a = 0; a < 4; a++)
          for (int b = 0; b < 4; b++) begin
            if (ci == 1) do_op(0, 3, 1, 0);  // flag set
            else         do_op(2, 0, 0, 1);  // flag cleared
            do_op(f, a, b, (a ^ b) & 1);
          end

    // R9: idle, operands change, outputs hold
    do_op(0, 2, 3, 0);  // res 1, flag 1
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      opa = W'(k);
      opb = W'(3 - k);
      @(negedge clk);
      chk(res_o == 1, "R9 result hold", res_o, 1);
      chk(cy_o == 1, "R9 flag hold", cy_o, 1);
    end

    // R10: second strobe on the load edge of the first
    @(negedge clk);
    fn_we = 1'b1; fn_val = 4'd0; opa = 2'd3; opb = 2'd3;
    @(negedge clk);
    fn_val = 4'd2;
    @(negedge clk);
    fn_we = 1'b0;
    chk(res_o == 0, "R10 still cleared", res_o, 0);
    chk(cy_o == 1, "R10 flag untouched", cy_o, 1);
    @(negedge clk);
    chk(res_o == 3, "R10 new selection loaded", res_o, 3);
    chk(cy_o == 0, "R10 new selection carry", cy_o, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule